// File: doc/BRIEF.md
# Conditional Relative Branch Evaluator

This block resolves a short relative jump in a small 8-bit processor core. An instruction is presented together with its condition selector, the current zero and carry flags, the program counter, and a signed 8-bit offset. The PC given is the one already advanced past the two-byte instruction. The block decides whether the branch is taken and produces the next program counter. It also reports how many clock cycles the instruction costs: taken and untaken branches cost different amounts.

Evaluation takes one clock. A request is accepted when `br_req` is high, and the result appears on the registered outputs in the next cycle, with `br_done` high for that one cycle. Between requests the result outputs keep their last values. Opcode decoding, operand fetch and all absolute control transfers are handled elsewhere.

Top module: `rel_branch_unit`

## Requirements
- R1: While reset is asserted and after its release, before the first request, `br_done`, `br_taken`, `bad_cond`, `next_pc` and `cost_cycles` are all zero.
- R2: `br_done` is high exactly in the cycle after a cycle with `br_req` high. In a cycle after one without a request, `next_pc`, `br_taken`, `cost_cycles` and `bad_cond` keep their values.
- R3: Selector code 0 (always) gives a taken branch whatever the flags are.
- R4: Selector code 4 is taken when `flag_z` is 0, and code 5 is taken when `flag_z` is 1. Both ignore `flag_c`.
- R5: Selector code 6 is taken when `flag_c` is 0, and code 7 is taken when `flag_c` is 1. Both ignore `flag_z`.
- R6: On a taken branch, `next_pc` equals `pc_in` plus the offset sign-extended from bit 7, wrapped modulo 2^16.
- R7: `cost_cycles` is 12 for a taken branch and 8 for an untaken one.
- R8: On an untaken branch, `next_pc` equals `pc_in` unchanged.
- R9: Selector codes 1, 2 and 3 raise `bad_cond` and are treated as untaken. Legal codes leave `bad_cond` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| br_req | input | 1 | Evaluate the presented branch this cycle |
| cond_sel | input | 3 | Condition selector (0 always, 4/5 zero tests, 6/7 carry tests) |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| pc_in | input | 16 | PC following the branch instruction |
| disp | input | 8 | Signed two's-complement offset |
| br_done | output | 1 | Result valid, one cycle after a request |
| br_taken | output | 1 | Branch was taken |
| next_pc | output | 16 | Program counter to continue from |
| cost_cycles | output | 4 | Clock cycles consumed by the instruction |
| bad_cond | output | 1 | Selector code was not a legal condition |

## Verification
The assertions assume that reset is held for at least one clock edge before requests start. They also assume that every input is stable around the rising edge, so that the value seen one cycle earlier is the value the design actually captured. The bench changes inputs only on the falling edge and issues requests back to back, with idle gaps in between. The gaps exercise the hold behaviour. The stimulus covers all eight selector codes, all four flag combinations, and PC and offset pairs that cross the 16-bit wrap in both directions.

// File: rtl/rel_branch_unit.sv
module rel_branch_unit #(
  parameter int PC_W       = 16,
  parameter int OFS_W      = 8,
  parameter int TAKEN_COST = 12,
  parameter int SKIP_COST  = 8,
  localparam int COST_W    = $clog2(TAKEN_COST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_req,
  input  logic [2:0]        cond_sel,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [OFS_W-1:0]  disp,
  output logic              br_done,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc,
  output logic [COST_W-1:0] cost_cycles,
  output logic              bad_cond
);

  logic hit, legal;

  always_comb begin
    legal = 1'b1;
    hit   = 1'b0;
    case (cond_sel)
      3'd0:    hit = 1'b1;
      3'd4:    hit = ~flag_z;
      3'd5:    hit = flag_z;
      3'd6:    hit = ~flag_c;
      3'd7:    hit = flag_c;
      default: legal = 1'b0;
    endcase
  end

  wire [PC_W-1:0] ofs_ext = {{(PC_W-OFS_W){disp[OFS_W-1]}}, disp};
  wire [PC_W-1:0] target  = pc_in + ofs_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_done     <= 1'b0;
      br_taken    <= 1'b0;
      next_pc     <= '0;
      cost_cycles <= '0;
      bad_cond    <= 1'b0;
    end else begin
      br_done <= br_req;
      if (br_req) begin
        br_taken    <= hit;
        next_pc     <= hit ? target : pc_in;
        cost_cycles <= hit ? COST_W'(TAKEN_COST) : COST_W'(SKIP_COST);
        bad_cond    <= ~legal;
      end
    end
  end

endmodule

// File: rtl/rel_branch_unit_chk.sv
module rel_branch_unit_chk #(
  parameter int PC_W       = 16,
  parameter int OFS_W      = 8,
  parameter int TAKEN_COST = 12,
  parameter int SKIP_COST  = 8,
  parameter int COST_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_req,
  input logic [2:0]        cond_sel,
  input logic              flag_z,
  input logic              flag_c,
  input logic [PC_W-1:0]   pc_in,
  input logic [OFS_W-1:0]  disp,
  input logic              br_done,
  input logic              br_taken,
  input logic [PC_W-1:0]   next_pc,
  input logic [COST_W-1:0] cost_cycles,
  input logic              bad_cond
);

  p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> br_done);

  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |=> !br_done);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_req |=> ($stable(next_pc) && $stable(br_taken) && $stable(cost_cycles)));

  p_always_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && cond_sel == 3'd0) |=> br_taken);

  p_zero_test_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && cond_sel == 3'd5) |=> (br_taken == $past(flag_z)));

  p_carry_test_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_req && cond_sel == 3'd7) |=> (br_taken == $past(flag_c)));

  p_taken_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_done && br_taken) |-> cost_cycles == COST_W'(TAKEN_COST));

  p_skip_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_done && !br_taken) |-> cost_cycles == COST_W'(SKIP_COST));

  p_skip_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_req |=> (br_taken || next_pc == $past(pc_in)));

  p_bad_untaken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (br_done && bad_cond) |-> !br_taken);

endmodule

bind rel_branch_unit rel_branch_unit_chk #(
  .PC_W(PC_W), .OFS_W(OFS_W), .TAKEN_COST(TAKEN_COST),
  .SKIP_COST(SKIP_COST), .COST_W(COST_W)
) u_chk (.*);

// File: tb/tb_rel_branch_unit.sv
module tb_rel_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_req = 1'b0;
  logic [2:0]  cond_sel = '0;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [15:0] pc_in = '0;
  logic [7:0]  disp = '0;
  logic        br_done, br_taken, bad_cond;
  logic [15:0] next_pc;
  logic [3:0]  cost_cycles;

  int checks = 0, fails = 0;
  bit finished = 0;

  // expected state of the outputs, updated behaviourally
  bit          e_done = 0, e_taken = 0, e_bad = 0;
  int          e_pc = 0, e_cost = 0;
  int          last_cond = 0;

  always #2.5 clk = ~clk;

  rel_branch_unit dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_for(input int c);
    if (c == 0) return "R3";
    if (c == 4 || c == 5) return "R4";
    if (c == 6 || c == 7) return "R5";
    return "R9";
  endfunction

  task automatic compare();
    chk(br_done == e_done, "R2", "done", br_done, e_done);
    chk(br_taken == e_taken, tag_for(last_cond), "taken", br_taken, e_taken);
    chk(int'(next_pc) == e_pc, e_taken ? "R6" : "R8", "next_pc", next_pc, e_pc);
    chk(int'(cost_cycles) == e_cost, "R7", "cost", cost_cycles, e_cost);
    chk(bad_cond == e_bad, "R9", "bad_cond", bad_cond, e_bad);
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit req, input int c, input bit z, input bit cf,
                      input int pc, input int d);
    bit go;
    int ofs;
    br_req = req; cond_sel = 3'(c); flag_z = z; flag_c = cf;
    pc_in = 16'(pc); disp = 8'(d);
    @(negedge clk);
    e_done = req;
    if (req) begin
      case (c)
        0: go = 1;
        4: go = !z;
        5: go = z;
        6: go = !cf;
        7: go = cf;
        default: go = 0;
      endcase
      ofs = (d >= 128) ? d - 256 : d;
      e_taken = go;
      e_bad = !(c == 0 || c >= 4);
      e_pc = go ? ((pc + ofs) % 65536 + 65536) % 65536 : pc;
      e_cost = go ? 12 : 8;
      last_cond = c;
    end
    compare();
  endtask

  initial begin
    int pcs[6] = '{16'h0000, 16'hFFFF, 16'hFFF0, 16'h0010, 16'h8000, 16'h1234};
    int ds[6]  = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hF0};
    @(negedge clk);
    @(negedge clk);
    chk(!br_done && !br_taken && !bad_cond && next_pc == 0 && cost_cycles == 0,
        "R1", "reset outputs", {br_done, br_taken, bad_cond}, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    chk(next_pc == 0 && cost_cycles == 0, "R1", "after release", next_pc, 0);
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 4; f++)
        for (int p = 0; p < 6; p++)
          for (int d = 0; d < 6; d++) begin
            step(1, c, f[0], f[1], pcs[p], ds[d]);
            if (d == 5) begin
              step(0, 3, ~f[0], ~f[1], 16'hABCD, 8'h55);
              step(0, 0, 1, 1, 0, 0);
            end
          end
    finished = 1;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < 100000 && !finished; cyc++) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule